// File: doc/BRIEF.md
# Serial Programming Address and Write Controller

This block is the target-side sequencer for the two-wire serial programming mode of a small flash microcontroller. It watches a high-voltage-detect input, which stands in for the analog comparator on the reset/program pin. Program/verify mode starts only when that input rises while the serial clock and data lines are both low. While the mode is active, the block holds the rest of the chip in reset, puts the pins into high-impedance input state, and drives a 14-bit word address.

The controller takes commands that a serial shifter upstream has already decoded. The address can only be cleared, stepped up by one, or moved to the configuration base at 0x2000. Data words go into a four-slot write latch. A programming request then produces one write strobe to the flash array model. The strobe covers either one word at any address, or a batch of four aligned words in program space only. A read request produces a read strobe at the current address.

Top module: `serprog_ctrl`

## Requirements
- R1: After `rst_n` is low, `mode_active`, `io_hiz`, `core_hold`, `addr`, `wr_data` and all strobes are 0.
- R2: A 0-to-1 step of `hv_en` while `ser_clk_in` and `ser_dat_in` are both 0 sets `mode_active`, `io_hiz` and `core_hold` on the next clock, with `addr` at 0 and the latch cleared.
- R3: A rise of `hv_en` while either serial line is 1 does not enter the mode. A level of `hv_en` that stays high does not enter the mode, even after the lines fall.
- R4: While the mode is active, `hv_en` at 0 clears `mode_active`, `addr` and `wr_data` on the next clock.
- R5: Command code 0 (address reset) sets `addr` to 0.
- R6: Command code 1 (increment) adds one to `addr` inside its space. 0x1FFF wraps to 0x0000 and 0x3FFF wraps to 0x2000, so bit 13 never changes.
- R7: Command code 2 (load configuration) sets `addr` to 0x2000.
- R8: Command code 3 (load data) stores `cmd_data` in latch slot `addr[1:0]`. Slot i appears at `wr_data[14*i +: 14]`.
- R9: Command code 4 with `quad_mode`=0 gives a one-cycle `prog_stb` with `prog_quad`=0 and `prog_addr`=`addr`, in either space.
- R10: Command code 4 with `quad_mode`=1 in program space gives `prog_stb` with `prog_quad`=1 and `prog_addr`=`addr` with its two low bits cleared, but only when `addr[1:0]`=3. At any other low bits it does nothing.
- R11: Command code 4 with `quad_mode`=1 while `addr`≥0x2000 gives a one-cycle `err` and no `prog_stb`.
- R12: Command code 5 (read) gives a one-cycle `rd_stb` with `rd_addr`=`addr`.
- R13: Commands have no effect while the mode is inactive. Codes 6 and 7 have no effect while the mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hv_en | input | 1 | High voltage present on the reset/program pin |
| ser_clk_in | input | 1 | Serial clock line level |
| ser_dat_in | input | 1 | Serial data line level |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 14 | Data word for load data |
| quad_mode | input | 1 | 1 selects the four-word program method |
| mode_active | output | 1 | Program/verify mode active |
| io_hiz | output | 1 | All pins forced to high-impedance input |
| core_hold | output | 1 | Rest of the chip held in reset |
| addr | output | 14 | Current word address |
| wr_data | output | 56 | Write latch, four 14-bit slots |
| prog_stb | output | 1 | Program strobe to the flash array |
| prog_quad | output | 1 | Strobe covers four words |
| prog_addr | output | 14 | Address of the word or first word written |
| err | output | 1 | Four-word request refused in configuration space |
| rd_stb | output | 1 | Read strobe |
| rd_addr | output | 14 | Read address |

## Verification
Entry is tried with a rise of `hv_en` while a serial line is high, and with a level that stays high while the lines fall. These separate true edge detection from level detection. Directed walks of 8191 increments in each space show whether the wrap stays inside the space or crosses into the other one. Four-word requests are issued at every low address pair and in both spaces, so a strobe that fires early, or fires in configuration space, shows up. Seeded random command streams, mixing both write methods, are compared word for word against a bench model of the counter and latch.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
    typedef enum logic [2:0] {
        OP_RST_ADDR  = 3'd0,
        OP_INC       = 3'd1,
        OP_LOAD_CFG  = 3'd2,
        OP_LOAD_DATA = 3'd3,
        OP_PROG      = 3'd4,
        OP_READ      = 3'd5
    } sp_op_e;
endpackage

// File: rtl/sp_entry_detect.sv
module sp_entry_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic hv_en,
    input  logic ser_clk_in,
    input  logic ser_dat_in,
    output logic active,
    output logic enter,
    output logic leave
);
    typedef struct packed {
        logic active;
        logic hv_prev;
    } ent_t;

    ent_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        enter        = !st_q.active && hv_en && !st_q.hv_prev && !ser_clk_in && !ser_dat_in;
        leave        = st_q.active && !hv_en;
        st_d.hv_prev = hv_en;
        if (enter)      st_d.active = 1'b1;
        else if (leave) st_d.active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && hv_en && !st_q.hv_prev && !ser_clk_in && !ser_dat_in) |=> active);
    assert_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !hv_en) |=> !active);
    assert_no_level_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && st_q.hv_prev) |=> !active);
endmodule

// File: rtl/sp_addr_counter.sv
module sp_addr_counter
    import serprog_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cmd_en,
    input  logic [2:0]        op,
    output logic [ADDR_W-1:0] pc
);
    localparam int MSB = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] CFG_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

    logic [ADDR_W-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (clear) begin
            pc_d = '0;
        end else if (cmd_en) begin
            case (op)
                OP_RST_ADDR: pc_d = '0;
                OP_INC:      pc_d = {pc_q[MSB], pc_q[MSB-1:0] + 1'b1};
                OP_LOAD_CFG: pc_d = CFG_BASE;
                default:     pc_d = pc_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;

    assert_inc_keeps_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && cmd_en && op == OP_INC) |=> pc_q[MSB] == $past(pc_q[MSB]));
    assert_cfg_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && cmd_en && op == OP_LOAD_CFG) |=> pc_q == CFG_BASE);
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> pc_q == '0);
endmodule

// File: rtl/sp_write_latch.sv
module sp_write_latch
    import serprog_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 14,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    cmd_en,
    input  logic [2:0]              op,
    input  logic [DATA_W-1:0]       data,
    input  logic [ADDR_W-1:0]       pc,
    input  logic                    quad_mode,
    output logic [WORDS*DATA_W-1:0] latch_flat,
    output logic                    prog_stb,
    output logic                    prog_quad,
    output logic [ADDR_W-1:0]       prog_addr,
    output logic                    err,
    output logic                    rd_stb,
    output logic [ADDR_W-1:0]       rd_addr
);
    localparam int LSB_W = $clog2(WORDS);
    localparam int MSB   = ADDR_W - 1;

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] words;
        logic                         prog;
        logic                         quad;
        logic [ADDR_W-1:0]            paddr;
        logic                         err;
        logic                         rd;
        logic [ADDR_W-1:0]            raddr;
    } wl_t;

    wl_t st_d, st_q;
    logic last_slot;

    assign last_slot = &pc[LSB_W-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.prog = 1'b0;
        st_d.err  = 1'b0;
        st_d.rd   = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (cmd_en) begin
            case (op)
                OP_LOAD_DATA: st_d.words[pc[LSB_W-1:0]] = data;
                OP_PROG: begin
                    if (!quad_mode) begin
                        st_d.prog  = 1'b1;
                        st_d.quad  = 1'b0;
                        st_d.paddr = pc;
                    end else if (pc[MSB]) begin
                        st_d.err = 1'b1;
                    end else if (last_slot) begin
                        st_d.prog  = 1'b1;
                        st_d.quad  = 1'b1;
                        st_d.paddr = {pc[MSB:LSB_W], {LSB_W{1'b0}}};
                    end
                end
                OP_READ: begin
                    st_d.rd    = 1'b1;
                    st_d.raddr = pc;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_flat = st_q.words;
    assign prog_stb   = st_q.prog;
    assign prog_quad  = st_q.quad;
    assign prog_addr  = st_q.paddr;
    assign err        = st_q.err;
    assign rd_stb     = st_q.rd;
    assign rd_addr    = st_q.raddr;

    assert_quad_in_program_space_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb && prog_quad) |-> !prog_addr[MSB]);
    assert_quad_base_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb && prog_quad) |-> prog_addr[LSB_W-1:0] == '0);
    assert_single_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, err, rd_stb}));
    assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb && !cmd_en) |=> !prog_stb);
endmodule

// File: rtl/serprog_ctrl.sv
module serprog_ctrl #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 14,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hv_en,
    input  logic                    ser_clk_in,
    input  logic                    ser_dat_in,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic [DATA_W-1:0]       cmd_data,
    input  logic                    quad_mode,
    output logic                    mode_active,
    output logic                    io_hiz,
    output logic                    core_hold,
    output logic [ADDR_W-1:0]       addr,
    output logic [WORDS*DATA_W-1:0] wr_data,
    output logic                    prog_stb,
    output logic                    prog_quad,
    output logic [ADDR_W-1:0]       prog_addr,
    output logic                    err,
    output logic                    rd_stb,
    output logic [ADDR_W-1:0]       rd_addr
);
    logic active, enter, leave, clear, cmd_en;

    sp_entry_detect i_entry (
        .clk(clk), .rst_n(rst_n), .hv_en(hv_en),
        .ser_clk_in(ser_clk_in), .ser_dat_in(ser_dat_in),
        .active(active), .enter(enter), .leave(leave)
    );

    assign clear  = enter | leave;
    assign cmd_en = active & cmd_valid & hv_en;

    sp_addr_counter #(.ADDR_W(ADDR_W)) i_pc (
        .clk(clk), .rst_n(rst_n), .clear(clear), .cmd_en(cmd_en),
        .op(cmd_op), .pc(addr)
    );

    sp_write_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) i_latch (
        .clk(clk), .rst_n(rst_n), .clear(clear), .cmd_en(cmd_en),
        .op(cmd_op), .data(cmd_data), .pc(addr), .quad_mode(quad_mode),
        .latch_flat(wr_data), .prog_stb(prog_stb), .prog_quad(prog_quad),
        .prog_addr(prog_addr), .err(err), .rd_stb(rd_stb), .rd_addr(rd_addr)
    );

    assign mode_active = active;
    assign io_hiz      = active;
    assign core_hold   = active;

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_active |=> !(prog_stb || err || rd_stb));
    assert_entry_addr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_active) |-> (addr == '0 && wr_data == '0));
endmodule

// File: tb/test_serprog_ctrl.sv
`timescale 1ns/1ps
module test_serprog_ctrl;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, hv_en, ser_clk_in, ser_dat_in, cmd_valid, quad_mode;
    logic [2:0]  cmd_op;
    logic [13:0] cmd_data;
    logic        mode_active, io_hiz, core_hold, prog_stb, prog_quad, err, rd_stb;
    logic [13:0] addr, prog_addr, rd_addr;
    logic [55:0] wr_data;

    serprog_ctrl i_serprog_ctrl (
        .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .ser_clk_in(ser_clk_in),
        .ser_dat_in(ser_dat_in), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .quad_mode(quad_mode), .mode_active(mode_active),
        .io_hiz(io_hiz), .core_hold(core_hold), .addr(addr), .wr_data(wr_data),
        .prog_stb(prog_stb), .prog_quad(prog_quad), .prog_addr(prog_addr),
        .err(err), .rd_stb(rd_stb), .rd_addr(rd_addr)
    );

    int checks = 0;
    int fails  = 0;
    logic [13:0]      m_pc;
    logic [3:0][13:0] m_lat;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] f_inc(logic [13:0] p);
        return {p[13], p[12:0] + 13'd1};
    endfunction

    function automatic string f_req(logic [2:0] op, logic q, logic [13:0] p);
        case (op)
            3'd0: return "R5";
            3'd1: return "R6";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return !q ? "R9" : (p[13] ? "R11" : "R10");
            3'd5: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic cmd(logic [2:0] op, logic [13:0] d, logic q);
        logic e_prog = 1'b0, e_quad = 1'b0, e_err = 1'b0, e_rd = 1'b0;
        logic [13:0] e_paddr = '0, e_raddr = '0;
        string r = f_req(op, q, m_pc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; quad_mode = q;
        case (op)
            3'd0: m_pc = '0;
            3'd1: m_pc = f_inc(m_pc);
            3'd2: m_pc = 14'h2000;
            3'd3: m_lat[m_pc[1:0]] = d;
            3'd4: begin
                if (!q) begin e_prog = 1'b1; e_paddr = m_pc; end
                else if (m_pc[13]) e_err = 1'b1;
                else if (m_pc[1:0] == 2'd3) begin
                    e_prog = 1'b1; e_quad = 1'b1; e_paddr = {m_pc[13:2], 2'b00};
                end
            end
            3'd5: begin e_rd = 1'b1; e_raddr = m_pc; end
            default: ;
        endcase
        @(posedge clk); #1;
        chk(r, 64'(addr), 64'(m_pc));
        chk(r, 64'(wr_data), 64'(m_lat));
        chk(r, 64'({prog_stb, err, rd_stb}), 64'({e_prog, e_err, e_rd}));
        if (e_prog) chk(r, 64'({prog_quad, prog_addr}), 64'({e_quad, e_paddr}));
        if (e_rd)   chk(r, 64'(rd_addr), 64'(e_raddr));
    endtask

    task automatic idle(int n);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; hv_en = 1'b0; ser_clk_in = 1'b0; ser_dat_in = 1'b0;
        cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0; quad_mode = 1'b0;
        repeat (3) @(posedge clk); #1;
        // R1
        chk("R1", 64'({mode_active, io_hiz, core_hold, prog_stb, err, rd_stb}), 64'(0));
        chk("R1", 64'({addr, wr_data}), 64'(0));
        @(negedge clk); rst_n = 1'b1;
        // R13: commands while inactive
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd2;
        @(posedge clk); #1;
        chk("R13", 64'({addr, prog_stb, err, rd_stb}), 64'(0));
        @(negedge clk); cmd_op = 3'd5;
        @(posedge clk); #1;
        chk("R13", 64'({addr, rd_stb}), 64'(0));
        idle(1);
        // R3: rise with clock line high
        @(negedge clk); ser_clk_in = 1'b1; hv_en = 1'b1;
        @(posedge clk); #1;
        chk("R3", 64'(mode_active), 64'(0));
        @(negedge clk); ser_clk_in = 1'b0;
        repeat (2) @(posedge clk); #1;
        chk("R3", 64'(mode_active), 64'(0));
        @(negedge clk); hv_en = 1'b0; ser_dat_in = 1'b1;
        @(negedge clk); hv_en = 1'b1;
        @(posedge clk); #1;
        chk("R3", 64'(mode_active), 64'(0));
        @(negedge clk); hv_en = 1'b0; ser_dat_in = 1'b0;
        // R2: valid entry
        @(negedge clk); hv_en = 1'b1;
        @(posedge clk); #1;
        chk("R2", 64'({mode_active, io_hiz, core_hold}), 64'h7);
        chk("R2", 64'({addr, wr_data}), 64'(0));
        m_pc = '0; m_lat = '0;
        // R8 / R10: four-word sequence
        cmd(3'd3, 14'h0A1, 1'b1);
        cmd(3'd4, 14'h0, 1'b1);
        cmd(3'd1, 14'h0, 1'b1);
        cmd(3'd3, 14'h1B2, 1'b1);
        cmd(3'd4, 14'h0, 1'b1);
        cmd(3'd1, 14'h0, 1'b1);
        cmd(3'd3, 14'h2C3, 1'b1);
        cmd(3'd4, 14'h0, 1'b1);
        cmd(3'd1, 14'h0, 1'b1);
        cmd(3'd3, 14'h3D4, 1'b1);
        cmd(3'd4, 14'h0, 1'b1);
        // R9: single word in program space
        cmd(3'd4, 14'h0, 1'b0);
        // R11 and R9 in configuration space
        cmd(3'd2, 14'h0, 1'b0);
        cmd(3'd3, 14'h3FFF, 1'b0);
        cmd(3'd1, 14'h0, 1'b0);
        cmd(3'd1, 14'h0, 1'b0);
        cmd(3'd1, 14'h0, 1'b0);
        cmd(3'd4, 14'h0, 1'b1);
        cmd(3'd4, 14'h0, 1'b0);
        cmd(3'd5, 14'h0, 1'b0);
        cmd(3'd6, 14'h155, 1'b1);
        cmd(3'd7, 14'h2AA, 1'b0);
        // R5 then R6 wrap in program space
        cmd(3'd0, 14'h0, 1'b0);
        for (int i = 0; i < 8191; i++) cmd(3'd1, 14'h0, 1'b0);
        chk("R6", 64'(addr), 64'h1FFF);
        cmd(3'd1, 14'h0, 1'b0);
        chk("R6", 64'(addr), 64'h0000);
        // R6 wrap in configuration space
        cmd(3'd2, 14'h0, 1'b0);
        for (int i = 0; i < 8191; i++) cmd(3'd1, 14'h0, 1'b0);
        chk("R6", 64'(addr), 64'h3FFF);
        cmd(3'd1, 14'h0, 1'b0);
        chk("R6", 64'(addr), 64'h2000);
        cmd(3'd0, 14'h0, 1'b0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            if (op == 3'd2 && $urandom_range(0, 3) != 0) op = 3'd1;
            cmd(op, 14'($urandom), 1'($urandom));
        end
        idle(2);
        // R4: exit
        @(negedge clk); hv_en = 1'b0;
        @(posedge clk); #1;
        chk("R4", 64'({mode_active, io_hiz, core_hold}), 64'(0));
        chk("R4", 64'({addr, wr_data}), 64'(0));
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd2;
        @(posedge clk); #1;
        chk("R13", 64'(addr), 64'(0));
        idle(1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule